// File: doc/BRIEF.md
# Cache Program Page Buffer Responder

This block stands in for the device side of a NAND flash while a host controller runs cache programming. The host presents already decoded command events (start of a page load, cache confirm, plain page confirm, status request, column move) together with data bytes. Bytes land in a cache register. A confirm moves the cache contents into a data register. The data register is then "programmed" for a fixed number of clock cycles, after which the page is presented on a wide output for one-cycle inspection.

The two registers overlap their work. A cache confirm frees the cache as soon as the copy is done, so the host can load the next page while the previous one is still programming. A second confirm that arrives while the array is busy waits until programming ends and only then starts its copy. The ready/busy output follows the cache-ready status bit. A separate array-ready bit tells the host when all programming has finished. A plain page confirm keeps ready/busy low until its own page is fully programmed. Copy and program durations are parameters in clock cycles. Failures are injected through a test input.

Top module: `pgbuf_cache_model`

## Requirements
- R1: A load command (code 1) presets every cache byte to all ones (when FILL_ON_LOAD is set) and moves the column pointer to `col_addr`. Each accepted data byte is stored at the pointer, and the pointer then advances by one. Byte i of a page appears on `arr_page[8*i+7:8*i]` once that page has been copied into the data register.
- R2: A cache confirm (code 2) with the array idle drives `rb_n` low for exactly COPY_CYC cycles. Array programming then runs for PROG_CYC cycles. `arr_commit` is high for one cycle, in the first cycle after programming ends.
- R3: A cache confirm accepted while the array is still programming holds `rb_n` low until that programming ends. It then keeps `rb_n` low for COPY_CYC further cycles, and the page programmed before it is the one shown at the first commit.
- R4: Status bit 6 is 1 exactly when the cache can accept a new page, and `rb_n` always equals it while status is enabled.
- R5: Status bit 5 is 1 only when no array program is running and no copy is active or waiting; if bit 5 is 1 then bit 6 is 1.
- R6: A page confirm (code 3) holds `rb_n` low until that page's array programming has ended: COPY_CYC+PROG_CYC cycles with the array idle.
- R7: A column command (code 5) inside an open load sequence moves the pointer to `col_addr` without clearing any byte already loaded.
- R8: Status bit 0 takes the value of `fail_inject` in the cycle that array programming ends, and holds it until the next program completes.
- R9: A data byte that arrives while bit 6 is 0, while no load sequence is open, or in the same cycle as a command is not stored. `wr_err` is high in the following cycle.
- R10: `status` reads 8'h00 until a status command (code 4). It then shows the live status byte until the next load command, and after that it reads 8'h00 again.
- R11: After reset `rb_n` is 1, `status`, `wr_err` and `arr_commit` are 0, and `arr_page` is all ones.
- R12: A cache confirm sampled in the same cycle as the last cycle of array programming starts its copy at once. `rb_n` is then low for exactly COPY_CYC cycles, starting in the cycle `arr_commit` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A decoded command event is present this cycle |
| cmd_code | input | 3 | 1 load, 2 cache confirm, 3 page confirm, 4 status, 5 column move |
| col_addr | input | COL_W | Column for load and column move |
| din_valid | input | 1 | A data byte is present this cycle |
| din | input | DATA_W | Data byte |
| fail_inject | input | 1 | Result to record when array programming ends (1 = fail) |
| rb_n | output | 1 | Ready/busy, low while the cache is busy |
| status | output | 8 | Status byte: bit 6 cache ready, bit 5 array ready, bit 0 fail |
| wr_err | output | 1 | One-cycle pulse after a refused data byte |
| arr_commit | output | 1 | One-cycle pulse when a page finishes programming |
| arr_page | output | PAGE_BYTES*DATA_W | Data register contents |

## Verification
The end of array programming and the start of the next cache-to-data copy can fall in the same cycle. This happens in two ways: a waiting confirm is released when the timer expires, or a fresh confirm is sampled exactly when the timer reaches its last count. The bench counts cycles from an earlier confirm so that it can place a confirm on that last cycle. It then expects `arr_commit` high, `rb_n` still low and bit 5 still 0 in the same cycle, and a busy period of exactly COPY_CYC cycles. A one-cycle slip in handing over the busy condition would show as COPY_CYC+1.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
   typedef enum logic [2:0] {
      OP_NONE       = 3'd0,
      OP_LOAD       = 3'd1,
      OP_CONF_CACHE = 3'd2,
      OP_CONF_PAGE  = 3'd3,
      OP_STATUS     = 3'd4,
      OP_COLUMN     = 3'd5
   } pg_op_e;

   localparam int ST_FAIL_BIT  = 0;
   localparam int ST_ARRAY_BIT = 5;
   localparam int ST_CACHE_BIT = 6;
endpackage

// File: rtl/pgbuf_cnt_timer.sv
module pgbuf_cnt_timer #(
   parameter int CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic last
);
   localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= CW'(CYC - 1);
      end else if (busy && cnt == '0) begin
         busy <= 1'b0;
      end else if (busy) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign last = busy && (cnt == '0);
endmodule

// File: rtl/pgbuf_cache_store.sv
module pgbuf_cache_store #(
   parameter int PAGE_BYTES   = 16,
   parameter int DATA_W       = 8,
   parameter bit FILL_ON_LOAD = 1'b1,
   localparam int COL_W       = $clog2(PAGE_BYTES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load,
   input  logic                         col_set,
   input  logic [COL_W-1:0]             col_val,
   input  logic                         wr_en,
   input  logic [DATA_W-1:0]            wr_data,
   output logic [PAGE_BYTES*DATA_W-1:0] page
);
   localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

   logic [COL_W-1:0] ptr;
   logic             clr;

   generate
      if (FILL_ON_LOAD) begin : g_fill
         assign clr = load;
      end else begin : g_keep
         assign clr = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (col_set) begin
         ptr <= col_val;
      end else if (wr_en) begin
         ptr <= (ptr == LAST_COL) ? '0 : ptr + 1'b1;
      end
   end

   for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            page[i*DATA_W +: DATA_W] <= '1;
         end else if (clr) begin
            page[i*DATA_W +: DATA_W] <= '1;
         end else if (wr_en && ptr == COL_W'(i)) begin
            page[i*DATA_W +: DATA_W] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/pgbuf_seq.sv
module pgbuf_seq
   import pgbuf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [2:0] cmd_code,
   input  logic       din_valid,
   input  logic       copy_busy,
   input  logic       copy_last,
   input  logic       prog_busy,
   input  logic       prog_last,
   output logic       cache_rdy,
   output logic       arr_rdy,
   output logic       load_acc,
   output logic       col_acc,
   output logic       wr_acc,
   output logic       wr_rej,
   output logic       copy_start,
   output logic       stat_en
);
   logic seq_open, pend, pend_final, copy_final, arr_final, hold;
   logic is_conf, conf_acc, conf_final, arr_free;

   assign cache_rdy  = !copy_busy && !pend && !hold;
   assign arr_rdy    = !prog_busy && !copy_busy && !pend;
   assign is_conf    = cmd_valid && (cmd_code == OP_CONF_CACHE || cmd_code == OP_CONF_PAGE);
   assign conf_final = (cmd_code == OP_CONF_PAGE);
   assign conf_acc   = is_conf && cache_rdy && seq_open;
   assign load_acc   = cmd_valid && cmd_code == OP_LOAD && cache_rdy;
   assign col_acc    = cmd_valid && cmd_code == OP_COLUMN && cache_rdy && seq_open;
   assign wr_acc     = din_valid && !cmd_valid && cache_rdy && seq_open;
   assign wr_rej     = din_valid && !wr_acc;
   assign arr_free   = !prog_busy || prog_last;
   assign copy_start = (conf_acc || pend) && arr_free;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq_open   <= 1'b0;
         pend       <= 1'b0;
         pend_final <= 1'b0;
         copy_final <= 1'b0;
         arr_final  <= 1'b0;
         hold       <= 1'b0;
         stat_en    <= 1'b0;
      end else begin
         if (load_acc) seq_open <= 1'b1;
         else if (conf_acc) seq_open <= 1'b0;

         if (copy_start) pend <= 1'b0;
         else if (conf_acc) pend <= 1'b1;

         if (conf_acc) pend_final <= conf_final;

         if (copy_start) copy_final <= conf_acc ? conf_final : pend_final;

         if (copy_last) arr_final <= copy_final;

         if (conf_acc && conf_final) hold <= 1'b1;
         else if (prog_last && arr_final) hold <= 1'b0;

         if (cmd_valid && cmd_code == OP_LOAD) stat_en <= 1'b0;
         else if (cmd_valid && cmd_code == OP_STATUS) stat_en <= 1'b1;
      end
   end
endmodule

// File: rtl/pgbuf_cache_model.sv
module pgbuf_cache_model
   import pgbuf_pkg::*;
#(
   parameter int PAGE_BYTES   = 16,
   parameter int DATA_W       = 8,
   parameter int COPY_CYC     = 4,
   parameter int PROG_CYC     = 64,
   parameter bit FILL_ON_LOAD = 1'b1,
   localparam int COL_W       = $clog2(PAGE_BYTES),
   localparam int PAGE_W      = PAGE_BYTES * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_code,
   input  logic [COL_W-1:0]  col_addr,
   input  logic              din_valid,
   input  logic [DATA_W-1:0] din,
   input  logic              fail_inject,
   output logic              rb_n,
   output logic [7:0]        status,
   output logic              wr_err,
   output logic              arr_commit,
   output logic [PAGE_W-1:0] arr_page
);
   if (PAGE_BYTES < 2) begin : g_bad_pages
      $error("PAGE_BYTES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (COPY_CYC < 1 || PROG_CYC < 1) begin : g_bad_time
      $error("COPY_CYC and PROG_CYC must be at least 1");
   end

   logic cache_rdy, arr_rdy, load_acc, col_acc, wr_acc, wr_rej, copy_start, stat_en;
   logic copy_busy, copy_last, prog_busy, prog_last;
   logic fail_q;
   logic [PAGE_W-1:0] cache_page;

   pgbuf_seq u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .din_valid(din_valid), .copy_busy(copy_busy), .copy_last(copy_last),
      .prog_busy(prog_busy), .prog_last(prog_last), .cache_rdy(cache_rdy),
      .arr_rdy(arr_rdy), .load_acc(load_acc), .col_acc(col_acc), .wr_acc(wr_acc),
      .wr_rej(wr_rej), .copy_start(copy_start), .stat_en(stat_en)
   );

   pgbuf_cnt_timer #(.CYC(COPY_CYC)) u_copy_tmr (
      .clk(clk), .rst_n(rst_n), .start(copy_start), .busy(copy_busy), .last(copy_last)
   );

   pgbuf_cnt_timer #(.CYC(PROG_CYC)) u_prog_tmr (
      .clk(clk), .rst_n(rst_n), .start(copy_last), .busy(prog_busy), .last(prog_last)
   );

   pgbuf_cache_store #(
      .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .FILL_ON_LOAD(FILL_ON_LOAD)
   ) u_cache (
      .clk(clk), .rst_n(rst_n), .load(load_acc), .col_set(load_acc || col_acc),
      .col_val(col_addr), .wr_en(wr_acc), .wr_data(din), .page(cache_page)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arr_page   <= '1;
         fail_q     <= 1'b0;
         arr_commit <= 1'b0;
         wr_err     <= 1'b0;
      end else begin
         if (copy_last) arr_page <= cache_page;
         if (prog_last) fail_q <= fail_inject;
         arr_commit <= prog_last;
         wr_err     <= wr_rej;
      end
   end

   always_comb begin
      status = 8'h00;
      if (stat_en) begin
         status[ST_CACHE_BIT] = cache_rdy;
         status[ST_ARRAY_BIT] = arr_rdy;
         status[ST_FAIL_BIT]  = fail_q;
      end
   end

   assign rb_n = cache_rdy;
endmodule

// File: rtl/pgbuf_cache_model_chk.sv
module pgbuf_cache_model_chk #(
   parameter int PAGE_BYTES = 16,
   parameter int DATA_W     = 8
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         cmd_valid,
   input logic [2:0]                   cmd_code,
   input logic                         din_valid,
   input logic                         rb_n,
   input logic [7:0]                   status,
   input logic                         wr_err,
   input logic                         arr_commit,
   input logic [PAGE_BYTES*DATA_W-1:0] arr_page
);
   assert_rb_fall_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rb_n) |-> $past(cmd_valid));

   assert_commit_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      arr_commit |=> !arr_commit);

   assert_page_moves_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(arr_page) |-> !$past(rb_n));

   assert_rb_tracks_bit6_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (status != 8'h00) |-> (status[6] == rb_n));

   assert_array_implies_cache_R5: assert property (@(posedge clk) disable iff (!rst_n)
      status[5] |-> status[6]);

   assert_err_needs_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(din_valid));

   assert_status_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 3'd1) |=> (status == 8'h00));
endmodule

bind pgbuf_cache_model pgbuf_cache_model_chk #(
   .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
   .din_valid(din_valid), .rb_n(rb_n), .status(status), .wr_err(wr_err),
   .arr_commit(arr_commit), .arr_page(arr_page)
);

// File: tb/pgbuf_cache_model_bench.sv
module pgbuf_cache_model_bench;
   localparam int PB = 16;
   localparam int DW = 8;
   localparam int C  = 4;
   localparam int P  = 64;
   localparam int CW = $clog2(PB);
   localparam int PW = PB * DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_code = 3'd0;
   logic [CW-1:0] col_addr = '0;
   logic          din_valid = 1'b0;
   logic [DW-1:0] din = '0;
   logic          fail_inject = 1'b0;
   logic          rb_n, wr_err, arr_commit;
   logic [7:0]    status;
   logic [PW-1:0] arr_page;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   logic [PW-1:0] cur;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pgbuf_cache_model #(.PAGE_BYTES(PB), .DATA_W(DW), .COPY_CYC(C), .PROG_CYC(P)) u_pgbuf_cache_model (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .col_addr(col_addr), .din_valid(din_valid), .din(din), .fail_inject(fail_inject),
      .rb_n(rb_n), .status(status), .wr_err(wr_err), .arr_commit(arr_commit),
      .arr_page(arr_page)
   );

   task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic send_cmd(input logic [2:0] code, input int col);
      cmd_valid = 1'b1; cmd_code = code; col_addr = CW'(col);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_code = 3'd0;
   endtask

   task automatic send_byte(input logic [DW-1:0] b);
      din_valid = 1'b1; din = b;
      @(negedge clk);
      din_valid = 1'b0;
   endtask

   task automatic load_page(input int col, input int n, input logic [7:0] base);
      cur = '1;
      send_cmd(3'd1, col);
      for (int i = 0; i < n; i++) begin
         send_byte(base + 8'(i));
         cur[((col + i) % PB)*8 +: 8] = base + 8'(i);
      end
      send_cmd(3'd4, 0);
   endtask

   task automatic rb_low_len(output int n);
      n = 0;
      while (rb_n === 1'b0) begin n++; @(negedge clk); end
   endtask

   task automatic wait_commit();
      while (arr_commit !== 1'b1) @(negedge clk);
   endtask

   task automatic wait_idle();
      send_cmd(3'd4, 0);
      while (status[5] !== 1'b1) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R11 rb_n", PW'(rb_n), PW'(1));
      chk("R11 status", PW'(status), PW'(0));
      chk("R11 wr_err/commit", PW'({wr_err, arr_commit}), PW'(0));
      chk("R11 arr_page", arr_page, '1);
   endtask

   task automatic t_status_gate();
      chk("R10 status off", PW'(status), PW'(0));
      send_cmd(3'd4, 0);
      chk("R10 status live idle", PW'(status), PW'(8'h60));
      send_cmd(3'd1, 0);
      chk("R10 status off after load", PW'(status), PW'(0));
   endtask

   task automatic t_first_cache();
      int n;
      load_page(0, 6, 8'h10);
      send_cmd(3'd2, 0);
      chk("R4 rb_n and bit6 low", PW'({rb_n, status[6]}), PW'(0));
      chk("R5 bit5 low in copy", PW'(status[5]), PW'(0));
      rb_low_len(n);
      chk("R2 copy length", PW'(n), PW'(C));
      chk("R4 rb_n and bit6 high", PW'({rb_n, status[6]}), PW'(2'b11));
      chk("R5 bit5 low in program", PW'(status[5]), PW'(0));
      n = 0;
      while (arr_commit !== 1'b1) begin n++; @(negedge clk); end
      chk("R2 program length", PW'(n), PW'(P));
      chk("R5 bit5 high when done", PW'(status[5]), PW'(1));
      chk("R1 page contents", arr_page, cur);
   endtask

   task automatic t_held_off();
      int n;
      logic [PW-1:0] pa;
      wait_idle();
      load_page(3, 5, 8'h40);
      pa = cur;
      send_cmd(3'd2, 0);
      rb_low_len(n);
      chk("R2 copy length page A", PW'(n), PW'(C));
      load_page(PB - 2, 4, 8'h70);
      send_cmd(3'd2, 0);
      chk("R3 busy after second confirm", PW'({rb_n, status[5]}), PW'(0));
      wait_commit();
      chk("R3 still busy at first commit", PW'(rb_n), PW'(0));
      chk("R3 first commit shows page A", arr_page, pa);
      rb_low_len(n);
      chk("R3 deferred copy length", PW'(n), PW'(C));
      @(negedge clk);
      wait_commit();
      chk("R1 pointer wrap page B", arr_page, cur);
   endtask

   task automatic t_same_cycle();
      int n, e0;
      wait_idle();
      load_page(0, 3, 8'h21);
      send_cmd(3'd2, 0);
      e0 = cyc;
      rb_low_len(n);
      load_page(5, 4, 8'h90);
      while (cyc < e0 + C + P - 1) @(negedge clk);
      send_cmd(3'd2, 0);
      chk("R12 commit with new copy", PW'({arr_commit, rb_n, status[5]}), PW'(3'b100));
      rb_low_len(n);
      chk("R12 copy length", PW'(n), PW'(C));
      @(negedge clk);
      wait_commit();
      chk("R12 page contents", arr_page, cur);
   endtask

   task automatic t_page_mode();
      int n;
      wait_idle();
      load_page(2, 7, 8'hB0);
      send_cmd(3'd3, 0);
      rb_low_len(n);
      chk("R6 busy length", PW'(n), PW'(C + P));
      chk("R6 commit at release", PW'(arr_commit), PW'(1));
      chk("R6 page contents", arr_page, cur);
   endtask

   task automatic t_column();
      int n;
      wait_idle();
      load_page(0, 4, 8'hA0);
      send_cmd(3'd5, 8);
      send_byte(8'hB0); send_byte(8'hB1);
      send_cmd(3'd5, 2);
      send_byte(8'hC2);
      cur[8*8 +: 8] = 8'hB0; cur[9*8 +: 8] = 8'hB1; cur[2*8 +: 8] = 8'hC2;
      send_cmd(3'd3, 0);
      rb_low_len(n);
      chk("R7 column moves keep bytes", arr_page, cur);
   endtask

   task automatic t_fail();
      int n;
      wait_idle();
      fail_inject = 1'b1;
      load_page(0, 2, 8'h01);
      send_cmd(3'd3, 0);
      rb_low_len(n);
      chk("R8 fail recorded", PW'(status[0]), PW'(1));
      fail_inject = 1'b0;
      @(negedge clk);
      chk("R8 fail held", PW'(status[0]), PW'(1));
      load_page(0, 2, 8'h03);
      send_cmd(3'd3, 0);
      rb_low_len(n);
      chk("R8 pass recorded", PW'(status[0]), PW'(0));
   endtask

   task automatic t_ignored();
      int n;
      wait_idle();
      load_page(0, 2, 8'h55);
      send_cmd(3'd2, 0);
      send_byte(8'h5A);
      chk("R9 err pulse while busy", PW'(wr_err), PW'(1));
      @(negedge clk);
      chk("R9 err pulse ends", PW'(wr_err), PW'(0));
      wait_commit();
      chk("R9 busy byte not stored", arr_page, cur);
      send_byte(8'h66);
      chk("R9 err without open sequence", PW'(wr_err), PW'(1));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_status_gate();
      t_first_cache();
      t_held_off();
      t_same_cycle();
      t_page_mode();
      t_column();
      t_fail();
      t_ignored();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog all requirements act=timeout exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule